// File: doc/BRIEF.md
# Sixteen-Bit Add/Subtract Unit with Status Byte

This block adds or subtracts two 16-bit words and folds in an incoming carry or borrow. It also builds a complete 8-bit status byte from scratch, using the flag positions of the classic 8-bit microprocessor family. The two words are the accumulator pair and a second operand. The carry or borrow comes from bit 0 of the status byte presented on `flags_in`. The block fits inside a datapath that already handles instruction decode, the register file and memory.

A one-cycle `start` strobe captures the operands. On that same clock edge the result and the new status byte are registered. `done` is high for the following cycle. While `start` stays low, the outputs hold their values. The adder is chosen by a parameter: the native arithmetic operator, or an explicit bit-by-bit ripple chain built by generate. Both variants give identical results.

Top module: `wide_addsub`

## Requirements
- R1: With `op_sub`=0, `result` equals (acc_in + opnd_in + flags_in[0]) mod 65536.
- R2: With `op_sub`=1, `result` equals (acc_in - opnd_in - flags_in[0]) mod 65536.
- R3: Status bit 0 (carry) is set when the 17-bit intermediate has a bit above bit 15 set. This is the carry out for add, and for subtract it means acc_in < opnd_in + flags_in[0].
- R4: Status bit 6 (zero) is set exactly when all 16 result bits are zero.
- R5: Status bit 7 (sign) equals result bit 15 and is clear for a zero result.
- R6: Status bit 2 (overflow) is bit 15 of (acc^res)&(opnd^res) for add, and of (acc^res)&(acc^opnd) for subtract.
- R7: Status bit 4 (half carry) is bit 12 of acc^opnd^res.
- R8: Status bit 1 (subtract marker) equals `op_sub` of the captured operation.
- R9: Status bits 5 and 3 are always zero. Bits 7..1 of `flags_in` have no effect on any output.
- R10: `result` and `flags_out` update on the clock edge that samples `start` high. `done` is high for exactly the cycle after that edge.
- R11: While `start` is low, `result` and `flags_out` keep their values and `done` stays low.
- R12: Synchronous active-high `rst` clears `result`, `flags_out` and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture strobe, one cycle per operation |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| acc_in | input | 16 | Accumulator pair operand |
| opnd_in | input | 16 | Second operand |
| flags_in | input | 8 | Incoming status byte; only bit 0 is used |
| result | output | 16 | Registered result |
| flags_out | output | 8 | Registered status byte |
| done | output | 1 | One-cycle pulse after a capture |

## Verification
On every cycle, the assertions check the strobe-to-pulse timing, the hold while idle, reset clearing, the constant-zero status bits 5 and 3, and that the subtract marker, zero flag and sign flag agree with the registered result. Carry, overflow and half carry depend on the arithmetic of the captured operands. Only the bench's reference model covers them, across random operands and directed boundaries such as 0x7FFF+1, 0xFFFF+1, 0x0000-1 and 0x8000-1. The bench also compares the native and ripple adder variants against each other.

// File: rtl/wide_addsub_pkg.sv
package wide_addsub_pkg;
   localparam int unsigned STAT_W   = 8;
   localparam int unsigned ST_CARRY = 0;
   localparam int unsigned ST_SUBOP = 1;
   localparam int unsigned ST_OVFL  = 2;
   localparam int unsigned ST_RSV3  = 3;
   localparam int unsigned ST_HALF  = 4;
   localparam int unsigned ST_RSV5  = 5;
   localparam int unsigned ST_ZERO  = 6;
   localparam int unsigned ST_SIGN  = 7;

   typedef enum logic {
      OP_ADDC = 1'b0,
      OP_SUBB = 1'b1
   } arith_op_e;

   typedef enum int unsigned {
      ADDER_NATIVE = 0,
      ADDER_RIPPLE = 1
   } adder_kind_e;
endpackage

// File: rtl/wide_addsub_core.sv
module wide_addsub_core
   import wide_addsub_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ADDER_KIND = ADDER_NATIVE
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   input  arith_op_e         op_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              carry_o
);
   localparam int unsigned EXT_W = DATA_W + 1;

   generate
      if (ADDER_KIND == ADDER_NATIVE) begin : g_native
         logic [EXT_W-1:0] ext;
         always_comb begin
            if (op_i == OP_SUBB)
               ext = {1'b0, a_i} - {1'b0, b_i} - EXT_W'(cin_i);
            else
               ext = {1'b0, a_i} + {1'b0, b_i} + EXT_W'(cin_i);
         end
         assign sum_o   = ext[DATA_W-1:0];
         assign carry_o = ext[DATA_W];
      end else if (ADDER_KIND == ADDER_RIPPLE) begin : g_ripple
         logic [DATA_W:0]   chain;
         logic [DATA_W-1:0] b_eff;
         logic              is_sub;
         assign is_sub   = (op_i == OP_SUBB);
         assign b_eff    = is_sub ? ~b_i : b_i;
         assign chain[0] = is_sub ? ~cin_i : cin_i;
         for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
            logic prop;
            assign prop          = a_i[gi] ^ b_eff[gi];
            assign sum_o[gi]     = prop ^ chain[gi];
            assign chain[gi + 1] = (a_i[gi] & b_eff[gi]) | (prop & chain[gi]);
         end
         assign carry_o = is_sub ? ~chain[DATA_W] : chain[DATA_W];
      end else begin : g_bad_kind
         $error("wide_addsub_core: unknown ADDER_KIND %0d", ADDER_KIND);
      end
   endgenerate
endmodule

// File: rtl/wide_addsub_status.sv
module wide_addsub_status
   import wide_addsub_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [DATA_W-1:0] sum_i,
   input  logic              carry_i,
   input  arith_op_e         op_i,
   output logic [STAT_W-1:0] stat_o
);
   localparam int unsigned TOP_BIT  = DATA_W - 1;
   localparam int unsigned NIB_EDGE = DATA_W - 4;

   logic [DATA_W-1:0] ovf_vec;
   logic [DATA_W-1:0] nib_vec;
   logic              is_zero;

   always_comb begin
      is_zero = (sum_i == '0);
      nib_vec = a_i ^ b_i ^ sum_i;
      if (op_i == OP_SUBB)
         ovf_vec = (a_i ^ sum_i) & (a_i ^ b_i);
      else
         ovf_vec = (a_i ^ sum_i) & (b_i ^ sum_i);

      stat_o           = '0;
      stat_o[ST_CARRY] = carry_i;
      stat_o[ST_SUBOP] = (op_i == OP_SUBB);
      stat_o[ST_OVFL]  = ovf_vec[TOP_BIT];
      stat_o[ST_HALF]  = nib_vec[NIB_EDGE];
      stat_o[ST_ZERO]  = is_zero;
      stat_o[ST_SIGN]  = sum_i[TOP_BIT] & ~is_zero;
      stat_o[ST_RSV3]  = 1'b0;
      stat_o[ST_RSV5]  = 1'b0;
   end
endmodule

// File: rtl/wide_addsub.sv
module wide_addsub
   import wide_addsub_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ADDER_KIND = ADDER_NATIVE
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              op_sub,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] opnd_in,
   input  logic [7:0]        flags_in,
   output logic [DATA_W-1:0] result,
   output logic [7:0]        flags_out,
   output logic              done
);
   generate
      if (DATA_W < 8 || (DATA_W % 4) != 0) begin : g_bad_width
         $error("wide_addsub: DATA_W %0d must be a multiple of 4 and at least 8", DATA_W);
      end
      if (STAT_W != 8) begin : g_bad_stat
         $error("wide_addsub: status byte must be 8 bits");
      end
   endgenerate

   arith_op_e         op_sel;
   logic [DATA_W-1:0] sum_w;
   logic              carry_w;
   logic [STAT_W-1:0] stat_w;

   assign op_sel = op_sub ? OP_SUBB : OP_ADDC;

   wide_addsub_core #(
      .DATA_W    (DATA_W),
      .ADDER_KIND(ADDER_KIND)
   ) u_core (
      .a_i    (acc_in),
      .b_i    (opnd_in),
      .cin_i  (flags_in[ST_CARRY]),
      .op_i   (op_sel),
      .sum_o  (sum_w),
      .carry_o(carry_w)
   );

   wide_addsub_status #(
      .DATA_W(DATA_W)
   ) u_status (
      .a_i    (acc_in),
      .b_i    (opnd_in),
      .sum_i  (sum_w),
      .carry_i(carry_w),
      .op_i   (op_sel),
      .stat_o (stat_w)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         result    <= '0;
         flags_out <= '0;
         done      <= 1'b0;
      end else begin
         done <= start;
         if (start) begin
            result    <= sum_w;
            flags_out <= stat_w;
         end
      end
   end
endmodule

// File: rtl/wide_addsub_chk.sv
module wide_addsub_chk #(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic              op_sub,
   input logic [DATA_W-1:0] result,
   input logic [7:0]        flags_out,
   input logic              done
);
   p_reset_clears_r12: assert property (@(posedge clk)
      rst |=> (result == '0 && flags_out == 8'h00 && !done));

   p_done_follows_start_r10: assert property (@(posedge clk) disable iff (rst)
      start |=> done);

   p_idle_no_done_r11: assert property (@(posedge clk) disable iff (rst)
      !start |=> (!done && $stable(result) && $stable(flags_out)));

   p_reserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
      (flags_out[5] == 1'b0 && flags_out[3] == 1'b0));

   p_subop_bit_r8: assert property (@(posedge clk) disable iff (rst)
      start |=> (flags_out[1] == $past(op_sub)));

   p_zero_flag_r4: assert property (@(posedge clk) disable iff (rst)
      done |-> (flags_out[6] == (result == '0)));

   p_sign_flag_r5: assert property (@(posedge clk) disable iff (rst)
      done |-> (flags_out[7] == result[DATA_W-1]));
endmodule

bind wide_addsub wide_addsub_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .start    (start),
   .op_sub   (op_sub),
   .result   (result),
   .flags_out(flags_out),
   .done     (done)
);

// File: tb/test_wide_addsub.sv
module test_wide_addsub;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        op_sub = 1'b0;
   logic [15:0] acc_in = '0;
   logic [15:0] opnd_in = '0;
   logic [7:0]  flags_in = '0;
   logic [15:0] result, result_rip;
   logic [7:0]  flags_out, flags_rip;
   logic        done, done_rip;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;
   bit          finished = 0;

   always #2 clk = ~clk;

   wide_addsub #(.DATA_W(16), .ADDER_KIND(0)) i_wide_addsub (
      .clk(clk), .rst(rst), .start(start), .op_sub(op_sub),
      .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
      .result(result), .flags_out(flags_out), .done(done));

   wide_addsub #(.DATA_W(16), .ADDER_KIND(1)) i_wide_addsub_rip (
      .clk(clk), .rst(rst), .start(start), .op_sub(op_sub),
      .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
      .result(result_rip), .flags_out(flags_rip), .done(done_rip));

   function automatic logic [23:0] ref_model(input logic [15:0] a, input logic [15:0] b,
                                             input logic ci, input logic sub);
      logic [31:0] t;
      logic [15:0] r, ov, hx;
      logic [7:0]  f;
      t  = sub ? (32'(a) - 32'(b) - 32'(ci)) : (32'(a) + 32'(b) + 32'(ci));
      r  = t[15:0];
      ov = sub ? ((a ^ r) & (a ^ b)) : ((a ^ r) & (b ^ r));
      hx = a ^ b ^ r;
      f  = 8'h00;
      f[0] = |t[31:16];
      f[1] = sub;
      f[2] = ov[15];
      f[4] = hx[12];
      f[6] = (r == 16'h0000);
      f[7] = r[15] && (r != 16'h0000);
      return {r, f};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [15:0] a, input logic [15:0] b,
                         input logic [7:0] fin, input logic sub);
      logic [23:0] e;
      logic [7:0]  ef;
      e  = ref_model(a, b, fin[0], sub);
      ef = e[7:0];
      @(negedge clk);
      acc_in = a; opnd_in = b; flags_in = fin; op_sub = sub; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(sub ? "R2 result" : "R1 result", 32'(result), 32'(e[23:8]));
      chk("R3 carry", 32'(flags_out[0]), 32'(ef[0]));
      chk("R4 zero", 32'(flags_out[6]), 32'(ef[6]));
      chk("R5 sign", 32'(flags_out[7]), 32'(ef[7]));
      chk("R6 overflow", 32'(flags_out[2]), 32'(ef[2]));
      chk("R7 half", 32'(flags_out[4]), 32'(ef[4]));
      chk("R8 subop", 32'(flags_out[1]), 32'(ef[1]));
      chk("R9 reserved", 32'({flags_out[5], flags_out[3]}), 32'(0));
      chk("R10 done", 32'(done), 32'(1));
      chk("R10 ripple variant", {result_rip, flags_rip, 7'd0, done_rip},
          {result, flags_out, 7'd0, done});
      acc_in = 16'($urandom); opnd_in = 16'($urandom);
      flags_in = 8'($urandom); op_sub = 1'($urandom);
      @(negedge clk);
      chk("R11 hold result", 32'(result), 32'(e[23:8]));
      chk("R11 hold flags", 32'(flags_out), 32'(ef));
      chk("R11 no done", 32'(done), 32'(0));
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4099));
      repeat (3) @(negedge clk);
      chk("R12 reset result", 32'(result), 32'(0));
      chk("R12 reset flags", 32'(flags_out), 32'(0));
      chk("R12 reset done", 32'(done), 32'(0));
      rst = 1'b0;

      run_op(16'h0000, 16'h0000, 8'h00, 1'b0);
      run_op(16'hFFFF, 16'h0001, 8'h00, 1'b0);
      run_op(16'hFFFF, 16'h0000, 8'h01, 1'b0);
      run_op(16'h7FFF, 16'h0001, 8'h00, 1'b0);
      run_op(16'h8000, 16'h8000, 8'h00, 1'b0);
      run_op(16'h0FFF, 16'h0001, 8'h00, 1'b0);
      run_op(16'h0000, 16'h0001, 8'h00, 1'b1);
      run_op(16'h8000, 16'h0001, 8'h00, 1'b1);
      run_op(16'h1234, 16'h1234, 8'h00, 1'b1);
      run_op(16'h1234, 16'h1234, 8'h01, 1'b1);
      run_op(16'h1000, 16'h0001, 8'h00, 1'b1);
      run_op(16'h4000, 16'h0003, 8'hFE, 1'b0);
      run_op(16'h4000, 16'h0003, 8'hFE, 1'b1);

      for (int i = 0; i < 150; i++)
         run_op(16'($urandom), 16'($urandom), 8'($urandom), 1'($urandom));

      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R12 reset after use", {result, flags_out, 7'd0, done}, 32'(0));

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule